// File: doc/BRIEF.md
# Indirect-Addressed Line Status Register Interface

This block is the processor-facing register port of a four-line driver controller. The port has one address bit, a write strobe, a read strobe and a data byte. When the address bit is low, an access reaches a small pointer register. When it is high, the access reaches whichever data register the pointer selects. The pointer selects one of four per-line status groups or the line enable register. Bit n of every group belongs to line n.

Three of the groups (low voltage, open loop, current overload) pass the detector inputs through live, so software should sample them more than once. The thermal overload group is sticky: a bit that the thermal block sets stays set until software clears it. Reading the pointer also returns a global over-temperature flag. An interrupt output follows the current-overload detectors whenever the interrupt enable held beside the pointer is set.

After each write to the line enable register, the block flags a settling window of a fixed number of clock cycles. During that window, a read of the register returns the value it held before the write.

Top module: `linedrv_status_regif`

## Requirements
- R1: While `rst_ni` is low and after its release, the pointer, the interrupt enable, the latched address bit, the thermal latch, the line enable register and the settling counter are all zero. `rdata_o` therefore shows the pointer view.
- R2: A write with `addr_i`=0 loads the pointer from `wdata_i[2:0]` and the interrupt enable from `wdata_i[3]`. While the latched address bit is 0, `rdata_o` = {`hot_i`, 3'b000, enable, pointer}.
- R3: Every write or read strobe captures `addr_i` into the latched address bit. With the latch at 1, `rdata_o` shows the register the pointer selects. Pointer codes 5, 6 and 7 read as 8'h00.
- R4: Pointer codes 0 (low voltage), 1 (open loop) and 2 (current overload) show `lowv_det_i`, `open_det_i` and `ovld_det_i` live in `rdata_o[3:0]`, with bits 7:4 at zero.
- R5: Pointer code 3 shows the thermal latch. A latch bit is set in the cycle after its `therm_set_i` bit is high. It is cleared only by a data write with the pointer at 3 and a 1 in the matching `wdata_i` bit. If set and clear meet in the same cycle, set wins.
- R6: `irq_o` is high exactly when the interrupt enable is 1 and any `ovld_det_i` bit is 1.
- R7: A data write with the pointer at 4 loads `wdata_i[3:0]` into the line enable register. The new value appears on `line_en_o` one cycle later.
- R8: After a line enable write, `busy_o` is high for exactly SETTLE_CYC cycles. A second write during that time restarts the window. While `busy_o` is high, pointer code 4 reads the value the register held before the latest write. Afterwards it reads the current value.
- R9: A data write with the pointer at 0, 1, 2, 5, 6 or 7 changes neither the line enable register nor the thermal latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 1 | 0 = pointer, 1 = selected data register |
| wr_i | input | 1 | Write strobe, one cycle |
| rd_i | input | 1 | Read strobe, one cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the latched address bit and the current pointer |
| lowv_det_i | input | 4 | Low-voltage detector per line |
| open_det_i | input | 4 | Open-loop detector per line |
| ovld_det_i | input | 4 | Current-overload detector per line |
| therm_set_i | input | 4 | Thermal overload set request per line |
| hot_i | input | 1 | Global over-temperature flag |
| line_en_o | output | 4 | Line enable register |
| busy_o | output | 1 | Line enable settling window active |
| irq_o | output | 1 | Current-overload interrupt, level |

## Verification
The assertions assume that `wr_i` and `rd_i` are never high in the same cycle, and that the detector inputs and `hot_i` change only between clock edges. The stimulus drives every input a quarter period after the rising edge and issues each strobe alone for one cycle. The detector inputs are changed only while no strobe is active. The thermal set-and-clear collision is produced on purpose, because R5 defines the result.

// File: rtl/lrif_pkg.sv
package lrif_pkg;
  typedef enum logic [2:0] {
    SEL_LOWV  = 3'd0,
    SEL_OPEN  = 3'd1,
    SEL_OVLD  = 3'd2,
    SEL_THERM = 3'd3,
    SEL_LEN   = 3'd4
  } sel_e;

  localparam int unsigned PTR_W = 3;
  localparam int unsigned IE_BIT = 3;
endpackage

// File: rtl/lrif_ptr_reg.sv
module lrif_ptr_reg
  import lrif_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             addr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [IE_BIT:0]  wdata_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             ie_o,
  output logic             a0_o
);
  // R1, R2, R3
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o <= '0;
      ie_o  <= 1'b0;
      a0_o  <= 1'b0;
    end else begin
      if (wr_i || rd_i) a0_o <= addr_i;
      if (wr_i && !addr_i) begin
        ptr_o <= wdata_i[PTR_W-1:0];
        ie_o  <= wdata_i[IE_BIT];
      end
    end
  end
endmodule

// File: rtl/lrif_therm_latch.sv
module lrif_therm_latch #(
  parameter int unsigned NLINES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NLINES-1:0] set_i,
  input  logic [NLINES-1:0] clr_i,
  output logic [NLINES-1:0] tor_o
);
  // R5: set dominates clear
  for (genvar g = 0; g < NLINES; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       tor_o[g] <= 1'b0;
      else if (set_i[g]) tor_o[g] <= 1'b1;
      else if (clr_i[g]) tor_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/lrif_len_reg.sv
module lrif_len_reg #(
  parameter int unsigned NLINES     = 4,
  parameter int unsigned SETTLE_CYC = 50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [NLINES-1:0] wdata_i,
  output logic [NLINES-1:0] len_o,
  output logic [NLINES-1:0] prev_o,
  output logic              busy_o
);
  localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYC);

  logic [CNT_W-1:0] cnt_q;

  // R7, R8
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_o  <= '0;
      prev_o <= '0;
      cnt_q  <= '0;
    end else if (we_i) begin
      prev_o <= len_o;
      len_o  <= wdata_i;
      cnt_q  <= CNT_LOAD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/lrif_rd_mux.sv
module lrif_rd_mux
  import lrif_pkg::*;
#(
  parameter int unsigned NLINES = 4,
  parameter int unsigned DW     = 8
) (
  input  logic             a0_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic             ie_i,
  input  logic             hot_i,
  input  logic [NLINES-1:0] lowv_i,
  input  logic [NLINES-1:0] open_i,
  input  logic [NLINES-1:0] ovld_i,
  input  logic [NLINES-1:0] tor_i,
  input  logic [NLINES-1:0] len_i,
  input  logic [NLINES-1:0] prev_i,
  input  logic             busy_i,
  output logic [DW-1:0]    rdata_o
);
  logic [NLINES-1:0] grp;

  always_comb begin
    case (sel_e'(ptr_i))
      SEL_LOWV:  grp = lowv_i;
      SEL_OPEN:  grp = open_i;
      SEL_OVLD:  grp = ovld_i;
      SEL_THERM: grp = tor_i;
      SEL_LEN:   grp = busy_i ? prev_i : len_i;
      default:   grp = '0;
    endcase
  end

  always_comb begin
    rdata_o = '0;
    if (a0_i) begin
      rdata_o[NLINES-1:0] = grp;
    end else begin
      rdata_o[PTR_W-1:0] = ptr_i;
      rdata_o[IE_BIT]    = ie_i;
      rdata_o[DW-1]      = hot_i;
    end
  end
endmodule

// File: rtl/linedrv_status_regif.sv
module linedrv_status_regif
  import lrif_pkg::*;
#(
  parameter int unsigned NLINES     = 4,
  parameter int unsigned DW         = 8,
  parameter int unsigned SETTLE_CYC = 50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [NLINES-1:0] lowv_det_i,
  input  logic [NLINES-1:0] open_det_i,
  input  logic [NLINES-1:0] ovld_det_i,
  input  logic [NLINES-1:0] therm_set_i,
  input  logic              hot_i,
  output logic [NLINES-1:0] line_en_o,
  output logic              busy_o,
  output logic              irq_o
);
  logic [PTR_W-1:0]  ptr_q;
  logic              ie_q;
  logic              a0_q;
  logic [NLINES-1:0] tor_q;
  logic [NLINES-1:0] len_prev;
  logic              data_wr;
  logic              len_we;
  logic [NLINES-1:0] tor_clr;
  logic              unused_wbits;

  assign data_wr = wr_i && addr_i;
  assign len_we  = data_wr && (ptr_q == SEL_LEN);
  assign tor_clr = (data_wr && (ptr_q == SEL_THERM)) ? wdata_i[NLINES-1:0] : '0;
  assign unused_wbits = ^wdata_i[DW-1:NLINES];

  lrif_ptr_reg u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .wdata_i (wdata_i[IE_BIT:0]),
    .ptr_o   (ptr_q),
    .ie_o    (ie_q),
    .a0_o    (a0_q)
  );

  lrif_therm_latch #(.NLINES(NLINES)) u_tor (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (therm_set_i),
    .clr_i  (tor_clr),
    .tor_o  (tor_q)
  );

  lrif_len_reg #(.NLINES(NLINES), .SETTLE_CYC(SETTLE_CYC)) u_len (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (len_we),
    .wdata_i (wdata_i[NLINES-1:0]),
    .len_o   (line_en_o),
    .prev_o  (len_prev),
    .busy_o  (busy_o)
  );

  lrif_rd_mux #(.NLINES(NLINES), .DW(DW)) u_mux (
    .a0_i    (a0_q),
    .ptr_i   (ptr_q),
    .ie_i    (ie_q),
    .hot_i   (hot_i),
    .lowv_i  (lowv_det_i),
    .open_i  (open_det_i),
    .ovld_i  (ovld_det_i),
    .tor_i   (tor_q),
    .len_i   (line_en_o),
    .prev_i  (len_prev),
    .busy_i  (busy_o),
    .rdata_o (rdata_o)
  );

  // R6: level interrupt
  assign irq_o = ie_q & (|ovld_det_i);
endmodule

// File: rtl/linedrv_status_regif_chk.sv
module linedrv_status_regif_chk #(
  parameter int unsigned NLINES = 4,
  parameter int unsigned DW     = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [DW-1:0]     wdata_i,
  input logic [DW-1:0]     rdata_o,
  input logic [NLINES-1:0] lowv_det_i,
  input logic [NLINES-1:0] ovld_det_i,
  input logic [NLINES-1:0] therm_set_i,
  input logic              hot_i,
  input logic [NLINES-1:0] line_en_o,
  input logic              busy_o,
  input logic              irq_o,
  input logic [2:0]        ptr_q,
  input logic              ie_q,
  input logic              a0_q,
  input logic [NLINES-1:0] tor_q
);
  a_r2_tbit_view: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a0_q |-> (rdata_o[DW-1] == hot_i && rdata_o[2:0] == ptr_q));

  a_r2_ptr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !addr_i) |=> (ptr_q == $past(wdata_i[2:0]) && ie_q == $past(wdata_i[3])));

  a_r3_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a0_q && ptr_q > 3'd4) |-> rdata_o == '0);

  a_r4_lowv_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a0_q && ptr_q == 3'd0) |-> rdata_o == DW'(lowv_det_i));

  a_r5_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|therm_set_i) |=> ((tor_q & $past(therm_set_i)) == $past(therm_set_i)));

  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i && ptr_q == 3'd3) |=> ((tor_q & $past(tor_q)) == $past(tor_q)));

  a_r6_irq_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_q |-> !irq_o);

  a_r6_irq_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_q && |ovld_det_i) |-> irq_o);

  a_r7_len_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i && ptr_q == 3'd4) |=> line_en_o == $past(wdata_i[NLINES-1:0]));

  a_r8_busy_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i && ptr_q == 3'd4) |=> busy_o);

  a_r9_len_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i && ptr_q != 3'd4) |=> $stable(line_en_o));

  a_r0_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && rd_i));
endmodule

bind linedrv_status_regif linedrv_status_regif_chk #(.NLINES(NLINES), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .wr_i        (wr_i),
  .rd_i        (rd_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .lowv_det_i  (lowv_det_i),
  .ovld_det_i  (ovld_det_i),
  .therm_set_i (therm_set_i),
  .hot_i       (hot_i),
  .line_en_o   (line_en_o),
  .busy_o      (busy_o),
  .irq_o       (irq_o),
  .ptr_q       (ptr_q),
  .ie_q        (ie_q),
  .a0_q        (a0_q),
  .tor_q       (tor_q)
);

// File: tb/linedrv_status_regif_test.sv
`timescale 1ns/1ps
module linedrv_status_regif_test;
  localparam int SETTLE = 50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr = 1'b0, wr = 1'b0, rd = 1'b0, hot = 1'b0;
  logic [7:0] wdata = '0;
  logic [3:0] lowv = '0, openl = '0, ovld = '0, tset = '0;
  logic [7:0] rdata;
  logic [3:0] len;
  logic       busy, irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  linedrv_status_regif #(.SETTLE_CYC(SETTLE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .lowv_det_i(lowv), .open_det_i(openl),
    .ovld_det_i(ovld), .therm_set_i(tset), .hot_i(hot), .line_en_o(len),
    .busy_o(busy), .irq_o(irq)
  );

  // behavioural reference
  int   m_ptr, m_cnt;
  bit   m_ie, m_a0;
  logic [3:0] m_tor, m_len, m_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ptr = 0; m_ie = 0; m_a0 = 0; m_tor = '0; m_len = '0; m_prev = '0; m_cnt = 0;
    end else begin
      logic [3:0] clr;
      bit load;
      clr = '0; load = 0;
      if (wr) begin
        m_a0 = addr;
        if (!addr) begin
          m_ptr = wdata[2:0]; m_ie = wdata[3];
        end else if (m_ptr == 3) clr = wdata[3:0];
        else if (m_ptr == 4) begin
          m_prev = m_len; m_len = wdata[3:0]; load = 1;
        end
      end
      if (rd) m_a0 = addr;
      m_tor = (m_tor & ~clr) | tset;
      if (load) m_cnt = SETTLE;
      else if (m_cnt > 0) m_cnt--;
    end
  end

  function automatic logic [7:0] exp_rdata();
    if (!m_a0) return {hot, 3'b000, m_ie, m_ptr[2:0]};
    case (m_ptr)
      0: return {4'h0, lowv};
      1: return {4'h0, openl};
      2: return {4'h0, ovld};
      3: return {4'h0, m_tor};
      4: return {4'h0, (m_cnt > 0) ? m_prev : m_len};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rd_tag();
    if (!m_a0) return "R2";
    if (m_ptr <= 2) return "R4";
    if (m_ptr == 3) return "R5";
    if (m_ptr == 4) return (m_cnt > 0) ? "R8" : "R7";
    return "R3";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(rd_tag(), 32'(rdata), 32'(exp_rdata()));
      chk("R6", 32'(irq), 32'(m_ie & (|ovld)));
      chk("R7/R9", 32'(len), 32'(m_len));
      chk("R8", 32'(busy), 32'(m_cnt > 0));
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic bus_wr(bit a, logic [7:0] d);
    addr = a; wdata = d; wr = 1; step(); wr = 0; step();
  endtask

  task automatic bus_rd(bit a);
    addr = a; rd = 1; step(); rd = 0; step();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    // R1: reset state while held
    chk("R1", 32'(rdata), 32'h00);
    chk("R1", 32'(len), 32'h0);
    chk("R1", 32'(busy), 32'h0);
    rst_n = 1; step(2);
    chk("R1", 32'(rdata), 32'h00);

    // R2: pointer view with T flag
    hot = 1; bus_wr(0, 8'h0A); step();
    chk("R2", 32'(rdata), 32'h8A);
    hot = 0; step();
    chk("R2", 32'(rdata), 32'h0A);

    // R4: live groups
    bus_wr(0, 8'h00); bus_rd(1);
    lowv = 4'h5; step(); chk("R4", 32'(rdata), 32'h05);
    lowv = 4'hC; step(); chk("R4", 32'(rdata), 32'h0C);
    bus_wr(0, 8'h01); bus_rd(1); openl = 4'h9; step();
    chk("R4", 32'(rdata), 32'h09);

    // R6: interrupt gating
    bus_wr(0, 8'h02); bus_rd(1); ovld = 4'h2; step();
    chk("R6", 32'(irq), 32'h0);
    bus_wr(0, 8'h0A); ovld = 4'h8; step();
    chk("R6", 32'(irq), 32'h1);
    ovld = 4'h0; step(); chk("R6", 32'(irq), 32'h0);
    ovld = 4'h4; bus_rd(1); chk("R4", 32'(rdata), 32'h04);

    // R5: thermal latch, partial clear, set beats clear
    bus_wr(0, 8'h03); bus_rd(1);
    tset = 4'h6; step(); tset = 4'h0; step(3);
    chk("R5", 32'(rdata), 32'h06);
    bus_wr(1, 8'h02); chk("R5", 32'(rdata), 32'h04);
    addr = 1; wdata = 8'h04; tset = 4'h4; wr = 1; step(); wr = 0; tset = 0; step();
    chk("R5", 32'(rdata), 32'h04);
    bus_wr(1, 8'h0F); chk("R5", 32'(rdata), 32'h00);

    // R7/R8: line enable and settling window
    bus_wr(0, 8'h04); bus_wr(1, 8'h0A);
    chk("R7", 32'(len), 32'hA);
    bus_rd(1); chk("R8", 32'(rdata), 32'h00); chk("R8", 32'(busy), 32'h1);
    step(SETTLE); chk("R8", 32'(busy), 32'h0);
    bus_rd(1); chk("R7", 32'(rdata), 32'h0A);
    bus_wr(1, 8'h05); step(10); bus_wr(1, 8'h03);
    step(SETTLE - 3); chk("R8", 32'(busy), 32'h1); chk("R8", 32'(rdata), 32'h05);
    step(3); chk("R8", 32'(busy), 32'h0); chk("R7", 32'(rdata), 32'h03);

    // R3/R9: unused codes and ignored writes
    tset = 4'h1; step(); tset = 0; step();
    for (int c = 5; c < 8; c++) begin
      bus_wr(0, 8'(c)); bus_rd(1);
      chk("R3", 32'(rdata), 32'h00);
      bus_wr(1, 8'hFF);
    end
    for (int c = 0; c < 3; c++) begin
      bus_wr(0, 8'(c)); bus_wr(1, 8'hFF);
    end
    chk("R9", 32'(len), 32'h3);
    bus_wr(0, 8'h03); bus_rd(1); chk("R9", 32'(rdata), 32'h01);
    bus_rd(0); chk("R3", 32'(rdata), 32'h03);

    step(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule